// File: doc/BRIEF.md
# Time-Multiplexed Gate Evaluation Processor Array

This block is a compact logic-emulation engine. A user netlist, already reduced offline to gates with at most four inputs and one output, runs on a small array of identical gate processors. Each processor holds its own instruction memory with one slot per step. In every step each processor reads up to four bits from a shared signal store, looks up the result in a 16-entry truth table, and writes one bit back. All processors write their results into the same store, so any processor can use any result that an earlier step produced.

A user clock cycle begins with a start pulse. The primary inputs and the current user-register values are copied into fixed store locations. The step counter then runs from zero to a programmable last step. One cycle later the user registers take their next-state bits from a fixed store window, the primary outputs are taken from another window, and `done_o` pulses. The schedule is loaded through a simple write port while the engine is idle.

Top module: `gate_array_emu`

## Requirements
- R1: After reset `done_o` is 0, `po_o` is all zeros, every user register is 0 and every signal-store bit is 0.
- R2: An instruction word written through `ld_word_i` to processor `ld_proc_i`, slot `ld_step_i`, has these fields (AW = `ADDR_W`): operand k (k=0..3) at bits [k*AW +: AW], destination at [4*AW +: AW], truth table at [5*AW +: 16], and the valid flag at bit 5*AW+16.
- R3: A valid slot writes the bit truth[{op3,op2,op1,op0}] to its destination. Here op k is the store bit that operand k addresses, and op0 is the least significant index bit.
- R4: The store address map is fixed. Primary input i sits at address i. User register k sits at address `NUM_PI`+k. The next state of register k is read from `NXT_BASE`+k. Primary output j is read from `PO_BASE`+j. The defaults are inputs 0..7, registers 8..15, next state 16..23 and outputs 24..31.
- R5: A write made in step s can be read from step s+1 onward. A read of that address within step s returns the value it held before the step. Store bits keep their values from one user cycle to the next unless something writes them.
- R6: When start is sampled at an idle edge E with last step L, the engine runs steps 0..L on consecutive cycles. `done_o` is high for exactly one cycle, after edge E+L+2, and low at every other time.
- R7: User registers and `po_o` change only at the commit edge that raises `done_o`. Between commits they hold their values whatever the inputs do.
- R8: Start is ignored while a user cycle is in progress. It causes no extra done pulse, and the input values present at that time have no effect.
- R9: When several processors write the same address in one step, the highest-numbered processor's value is stored.
- R10: A slot whose valid flag is 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Instruction write strobe |
| ld_proc_i | input | PROC_W (2) | Target processor |
| ld_step_i | input | STEP_W (4) | Target step slot |
| ld_word_i | input | INSTR_W (47) | Instruction word |
| last_step_i | input | STEP_W (4) | Final step index, sampled with start |
| start_i | input | 1 | Begin one user cycle (taken when idle) |
| pi_i | input | NUM_PI (8) | Primary inputs, sampled with start |
| done_o | output | 1 | One-cycle pulse when the user cycle commits |
| po_o | output | NUM_PO (8) | Primary outputs captured at commit |

## Verification
A wrong step count or a wrong state transition moves the `done_o` pulse away from edge E+L+2, or duplicates it, so the error shows in the same user cycle. A broken operand index, truth-table lookup or write-priority decision corrupts a primary-output bit that the test schedule routes to that feature, and the bit is compared at the next done pulse. Errors in the user registers or in bits carried over between cycles, such as a store bit read in the same step it is written, appear one user cycle later. They show through outputs that copy the register values and the previous cycle's result.

// File: rtl/emu_pkg.sv
package emu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_COMMIT = 2'd2
   } emu_state_e;

   localparam int TT_BITS    = 16;
   localparam int GATE_FANIN = 4;

   function automatic logic lut_eval(input logic [TT_BITS-1:0] tt,
                                     input logic [GATE_FANIN-1:0] sel);
      return tt[sel];
   endfunction

endpackage

// File: rtl/emu_step_ctrl.sv
module emu_step_ctrl
   import emu_pkg::*;
#(
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [STEP_W-1:0] last_step_i,
   output logic              load_o,
   output logic              run_o,
   output logic              commit_o,
   output logic              done_o,
   output logic [STEP_W-1:0] step_o
);

   emu_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] last_q;
   logic              done_q;

   assign load_o   = start_i && (state_q == ST_IDLE);
   assign run_o    = (state_q == ST_RUN);
   assign commit_o = (state_q == ST_COMMIT);
   assign done_o   = done_q;
   assign step_o   = step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         last_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  step_q  <= '0;
                  last_q  <= last_step_i;
               end
            end
            ST_RUN: begin
               if (step_q == last_q) state_q <= ST_COMMIT;
               else                  step_q  <= step_q + 1'b1;
            end
            ST_COMMIT: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (step_q <= last_q)); // R6
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && step_q != last_q) |=> (run_o && step_q == STEP_W'($past(step_q) + 1'b1))); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6
   AST_COMMIT_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> (done_q && !run_o)); // R7

endmodule

// File: rtl/emu_gate_proc.sv
module emu_gate_proc
   import emu_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int DEPTH   = 16,
   parameter int STEP_W  = 4,
   parameter int INSTR_W = 47
) (
   input  logic               clk,
   input  logic               ld_en_i,
   input  logic [STEP_W-1:0]  ld_step_i,
   input  logic [INSTR_W-1:0] ld_word_i,
   input  logic               run_i,
   input  logic [STEP_W-1:0]  step_i,
   input  logic [(1<<ADDR_W)-1:0] store_i,
   output logic               wr_en_o,
   output logic [ADDR_W-1:0]  wr_addr_o,
   output logic               wr_data_o
);

   localparam int DST_LSB = GATE_FANIN * ADDR_W;
   localparam int TT_LSB  = DST_LSB + ADDR_W;
   localparam int VLD_BIT = TT_LSB + TT_BITS;

   logic [INSTR_W-1:0]    imem [DEPTH];
   logic [INSTR_W-1:0]    inst;
   logic [GATE_FANIN-1:0] sel;

   always_ff @(posedge clk) begin
      if (ld_en_i) imem[ld_step_i] <= ld_word_i;
   end

   assign inst = imem[step_i];

   for (genvar k = 0; k < GATE_FANIN; k++) begin : g_operand
      assign sel[k] = store_i[inst[k*ADDR_W +: ADDR_W]];
   end

   assign wr_en_o   = run_i && inst[VLD_BIT];
   assign wr_addr_o = inst[DST_LSB +: ADDR_W];
   assign wr_data_o = lut_eval(inst[TT_LSB +: TT_BITS], sel);

endmodule

// File: rtl/emu_signal_store.sv
module emu_signal_store #(
   parameter int ADDR_W   = 6,
   parameter int NUM_PROC = 4,
   parameter int NUM_PI   = 8,
   parameter int NUM_REG  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load_i,
   input  logic [NUM_PI-1:0]                pi_i,
   input  logic [NUM_REG-1:0]               reg_i,
   input  logic [NUM_PROC-1:0]              wr_en_i,
   input  logic [NUM_PROC-1:0][ADDR_W-1:0]  wr_addr_i,
   input  logic [NUM_PROC-1:0]              wr_data_i,
   output logic [(1<<ADDR_W)-1:0]           store_o
);

   localparam int STORE_N = 1 << ADDR_W;

   logic [STORE_N-1:0] store_q;

   // Later processors in the loop override earlier ones on an address clash.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else if (load_i) begin
         store_q[0 +: NUM_PI]       <= pi_i;
         store_q[NUM_PI +: NUM_REG] <= reg_i;
      end else begin
         for (int p = 0; p < NUM_PROC; p++) begin
            if (wr_en_i[p]) store_q[wr_addr_i[p]] <= wr_data_i[p];
         end
      end
   end

   assign store_o = store_q;

   AST_LOAD_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (store_q[0 +: NUM_PI] == $past(pi_i))); // R4
   AST_LOAD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (store_q[NUM_PI +: NUM_REG] == $past(reg_i))); // R4
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && wr_en_i == '0) |=> $stable(store_q)); // R10

endmodule

// File: rtl/gate_array_emu.sv
module gate_array_emu
   import emu_pkg::*;
#(
   parameter int NUM_PROC   = 4,
   parameter int ADDR_W     = 6,
   parameter int STEP_DEPTH = 16,
   parameter int NUM_PI     = 8,
   parameter int NUM_REG    = 8,
   parameter int NUM_PO     = 8,
   parameter int NXT_BASE   = 16,
   parameter int PO_BASE    = 24,
   localparam int STEP_W    = $clog2(STEP_DEPTH),
   localparam int PROC_W    = $clog2(NUM_PROC),
   localparam int INSTR_W   = (GATE_FANIN + 1) * ADDR_W + TT_BITS + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en_i,
   input  logic [PROC_W-1:0]  ld_proc_i,
   input  logic [STEP_W-1:0]  ld_step_i,
   input  logic [INSTR_W-1:0] ld_word_i,
   input  logic [STEP_W-1:0]  last_step_i,
   input  logic               start_i,
   input  logic [NUM_PI-1:0]  pi_i,
   output logic               done_o,
   output logic [NUM_PO-1:0]  po_o
);

   localparam int STORE_N = 1 << ADDR_W;

   if (NUM_PROC < 2) begin : g_chk_proc
      $error("NUM_PROC must be at least 2");
   end
   if ((1 << STEP_W) != STEP_DEPTH) begin : g_chk_depth
      $error("STEP_DEPTH must be a power of two");
   end
   if (NXT_BASE < NUM_PI + NUM_REG) begin : g_chk_nxt
      $error("next-state window overlaps inputs or registers");
   end
   if (PO_BASE < NXT_BASE + NUM_REG || PO_BASE + NUM_PO > STORE_N) begin : g_chk_po
      $error("output window misplaced");
   end

   logic                            load, run, commit;
   logic [STEP_W-1:0]               step;
   logic [STORE_N-1:0]              store;
   logic [NUM_PROC-1:0]             wr_en;
   logic [NUM_PROC-1:0][ADDR_W-1:0] wr_addr;
   logic [NUM_PROC-1:0]             wr_data;
   logic [NUM_REG-1:0]              reg_q;
   logic [NUM_PO-1:0]               po_q;

   emu_step_ctrl #(.STEP_W(STEP_W)) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .last_step_i (last_step_i),
      .load_o      (load),
      .run_o       (run),
      .commit_o    (commit),
      .done_o      (done_o),
      .step_o      (step)
   );

   for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
      emu_gate_proc #(
         .ADDR_W  (ADDR_W),
         .DEPTH   (STEP_DEPTH),
         .STEP_W  (STEP_W),
         .INSTR_W (INSTR_W)
      ) i_proc (
         .clk       (clk),
         .ld_en_i   (ld_en_i && (ld_proc_i == PROC_W'(p))),
         .ld_step_i (ld_step_i),
         .ld_word_i (ld_word_i),
         .run_i     (run),
         .step_i    (step),
         .store_i   (store),
         .wr_en_o   (wr_en[p]),
         .wr_addr_o (wr_addr[p]),
         .wr_data_o (wr_data[p])
      );
   end

   emu_signal_store #(
      .ADDR_W   (ADDR_W),
      .NUM_PROC (NUM_PROC),
      .NUM_PI   (NUM_PI),
      .NUM_REG  (NUM_REG)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .pi_i      (pi_i),
      .reg_i     (reg_q),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .store_o   (store)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
         po_q  <= '0;
      end else if (commit) begin
         reg_q <= store[NXT_BASE +: NUM_REG];
         po_q  <= store[PO_BASE +: NUM_PO];
      end
   end

   assign po_o = po_q;

   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(reg_q)); // R7
   AST_PO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(po_q)); // R7
   AST_NXT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (reg_q == $past(store[NXT_BASE +: NUM_REG]))); // R4
   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (wr_en == '0)); // R10

endmodule

// File: tb/test_gate_array_emu.sv
`timescale 1ns/1ps
module test_gate_array_emu;

   localparam int AW = 6;
   localparam int SW = 4;
   localparam int IW = 5*AW + 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_en_i = 1'b0;
   logic [1:0]    ld_proc_i = '0;
   logic [SW-1:0] ld_step_i = '0;
   logic [IW-1:0] ld_word_i = '0;
   logic [SW-1:0] last_step_i = '0;
   logic          start_i = 1'b0;
   logic [7:0]    pi_i = '0;
   logic          done_o;
   logic [7:0]    po_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q [$];

   // bench model of the loaded schedule
   logic       m_r0 = 1'b0, m_r1 = 1'b0, m_g36 = 1'b0;
   logic [7:0] m_po = '0;

   localparam logic [15:0] TT_AND = 16'h8888, TT_OR = 16'hEEEE, TT_XOR = 16'h6666;
   localparam logic [15:0] TT_BUF = 16'hAAAA, TT_NOT = 16'h5555, TT_ONE = 16'hFFFF, TT_ZERO = 16'h0000;

   gate_array_emu i_gate_array_emu (
      .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en_i), .ld_proc_i(ld_proc_i),
      .ld_step_i(ld_step_i), .ld_word_i(ld_word_i), .last_step_i(last_step_i),
      .start_i(start_i), .pi_i(pi_i), .done_o(done_o), .po_o(po_o)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R2 word layout: {valid, truth, dst, op3, op2, op1, op0}
   task automatic load_slot(input int p, input int s, input bit v, input logic [15:0] tt,
                            input int dst, input int a1, input int a0);
      @(negedge clk);
      ld_en_i   = 1'b1;
      ld_proc_i = 2'(p);
      ld_step_i = SW'(s);
      ld_word_i = {v, tt, AW'(dst), AW'(0), AW'(0), AW'(a1), AW'(a0)};
      @(negedge clk);
      ld_en_i = 1'b0;
   endtask

   function automatic string bit_req(input int j);
      case (j)
         0, 1:    return "R2_R3";
         2, 3:    return "R5";
         4:       return "R9";
         5:       return "R10";
         default: return "R4_R7";
      endcase
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            for (int j = 0; j < 8; j++)
               chk(po_o[j] == e[j], bit_req(j), {24'd0, po_o}, {24'd0, e});
         end
      end
   end

   task automatic run_user(input logic [7:0] pi, input int last, input bit inject);
      logic [7:0] nx;
      nx = m_po;
      nx[0] = (pi[0] & pi[1]) | (pi[2] ^ pi[3]);
      nx[2] = m_g36;
      if (last >= 3) begin
         nx[1] = pi[4] | pi[5];
         nx[3] = ~pi[0];
         nx[4] = pi[7];
         nx[5] = 1'b0;
         nx[6] = m_r0;
         nx[7] = m_r1;
      end
      m_g36 = ~pi[0];
      m_r0  = ~m_r0;
      m_r1  = m_r1 ^ pi[6];
      m_po  = nx;
      exp_q.push_back(nx);
      @(negedge clk);
      pi_i = pi;
      last_step_i = SW'(last);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 1; k <= last + 1; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk(done_o == 1'b0, inject ? "R8 done early" : "R6 done early", {31'd0, done_o}, 32'd0);
         start_i = inject && (k == 1);
         pi_i    = (inject && (k == 1)) ? ~pi : pi;
         last_step_i = (inject && (k == 1)) ? SW'(0) : SW'(last);
      end
      start_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b1, "R6 done timing", {31'd0, done_o}, 32'd1);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R6 done pulse width", {31'd0, done_o}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0, "R1 done", {31'd0, done_o}, 32'd0);
      chk(po_o == 8'd0, "R1 po", {24'd0, po_o}, 32'd0);

      // step 0
      load_slot(0, 0, 1, TT_AND, 32, 1, 0);
      load_slot(1, 0, 1, TT_XOR, 33, 3, 2);
      load_slot(2, 0, 1, TT_NOT, 16, 0, 8);
      load_slot(3, 0, 1, TT_OR,  35, 5, 4);
      // step 1
      load_slot(0, 1, 1, TT_OR,  24, 33, 32);
      load_slot(1, 1, 1, TT_BUF, 26, 0, 36);
      load_slot(2, 1, 1, TT_NOT, 36, 0, 0);
      load_slot(3, 1, 1, TT_XOR, 17, 6, 9);
      // step 2
      load_slot(0, 2, 1, TT_BUF, 30, 0, 8);
      load_slot(1, 2, 1, TT_ONE, 28, 0, 0);
      load_slot(2, 2, 1, TT_ZERO, 28, 0, 0);
      load_slot(3, 2, 1, TT_BUF, 28, 0, 7);
      // step 3
      load_slot(0, 3, 0, TT_ONE, 29, 0, 0);
      load_slot(1, 3, 1, TT_BUF, 31, 0, 9);
      load_slot(2, 3, 1, TT_BUF, 27, 0, 36);
      load_slot(3, 3, 1, TT_BUF, 25, 0, 35);

      run_user(8'b0000_0011, 3, 1'b0);
      run_user(8'b1100_0100, 3, 1'b1);
      run_user(8'b0101_1010, 1, 1'b0);
      run_user(8'b1111_1111, 3, 1'b0);
      run_user(8'b0110_0001, 3, 1'b0);
      run_user(8'b1001_1110, 3, 1'b1);

      // R7: outputs hold with no start while inputs move
      pi_i = 8'hA5;
      repeat (6) @(negedge clk);
      chk(po_o == m_po, "R7 hold", {24'd0, po_o}, {24'd0, m_po});
      chk(done_o == 1'b0, "R7 no done", {31'd0, done_o}, 32'd0);
      chk(exp_q.size() == 0, "R8 pending", exp_q.size(), 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule